// File: doc/BRIEF.md
# Clock Divide and Output Mode Mux

This block sits between the clock synthesizers and the output pads of a motherboard clock generator. It takes three running clocks: a CPU-domain source at twice the CPU output rate, a USB-domain source at twice the 48 MHz rate, and the reference-oscillator clock. From these it builds the CPU, SDRAM, PCI (six stoppable plus one free-running), USB/IO, IOAPIC and reference output clocks. Every divided output is the output of a flip-flop, so each one has a clean 50% duty cycle and its edges are tied to its source clock.

A configuration register lives in the reference-clock domain. A one-cycle write strobe loads it, and the strobe has no back-pressure. The register holds a two-bit mode field, one 48/24 MHz select bit per USB/IO output, and one enable bit per output. The mode field moves all outputs at once. In normal mode they run from the synthesized clocks. In test mode they run from the reference input, which then carries a test clock, through fixed divisions. In high-impedance mode the pad output-enable drops. Ratio and enable changes take effect only at the end of an output's low phase, so no output ever shows a shortened pulse.

Top module: `clkdiv_outmux`

## Requirements
- R1: In mode code 00, every CPU and SDRAM output toggles on each rising edge of `clk_cpu2x`. Its period is two source cycles and its high time is one source cycle.
- R2: In mode code 00, every PCI output, including the free-running one, runs at a quarter of the `clk_cpu2x` rate. That is half the CPU output rate, with a high time of two source cycles.
- R3: In mode code 00, USB/IO output k runs at half the `clk_usb2x` rate when select bit k is 1 (48 MHz) and at a quarter of that rate when the bit is 0 (24 MHz). Both select bits reset to 1.
- R4: The mode field is decoded as follows: 00 is normal, 01 is test, 11 is high impedance, and 10 behaves exactly like 00. `pad_oe` is 0 in mode 11 and 1 in every other mode. In mode 11 the internal clocks continue as in normal mode.
- R5: In mode code 01, the test clock is `clk_ref`. CPU and SDRAM outputs, and USB/IO outputs whose select bit is 1, run at test clock/2. PCI outputs, including the free-running one, and USB/IO outputs whose select bit is 0, run at test clock/4.
- R6: When enabled, the IOAPIC output and both reference outputs follow `clk_ref` in every mode.
- R7: An output whose enable bit is 0 stays low and produces no rising edge.
- R8: A change of enable bit, select bit or mode within a domain takes effect only at a period boundary while the output is low. Every high pulse therefore has the full half-period of either the old setting or the new one.
- R9: The configuration register loads only on a `clk_ref` rising edge with `cfg_we` high. A synchronous active-low reset sets mode 00, all enables to 1 and both USB/IO selects to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu2x | input | 1 | CPU-domain source, twice the CPU output rate |
| clk_usb2x | input | 1 | USB-domain source, twice the 48 MHz rate |
| clk_ref | input | 1 | Reference oscillator clock; test clock in mode 01 |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every domain |
| cfg_we | input | 1 | Configuration write strobe, `clk_ref` domain |
| cfg_mode | input | 2 | Mode field: 00 normal, 01 test, 11 high impedance, 10 as 00 |
| cfg_usb48 | input | 2 | Per USB/IO output: 1 selects 48 MHz, 0 selects 24 MHz |
| cfg_cpu_en | input | 4 | CPU output enables |
| cfg_sdr_en | input | 8 | SDRAM output enables |
| cfg_pci_en | input | 7 | PCI output enables; bit 6 is the free-running output |
| cfg_usb_en | input | 2 | USB/IO output enables |
| cfg_apic_en | input | 1 | IOAPIC output enable |
| cfg_ref_en | input | 2 | Reference output enables |
| cpu_clk | output | 4 | CPU clocks |
| sdr_clk | output | 8 | SDRAM clocks |
| pci_clk | output | 6 | PCI clocks |
| pci_f_clk | output | 1 | Free-running PCI clock |
| usb_clk | output | 2 | USB/IO clocks |
| apic_clk | output | 1 | IOAPIC clock |
| ref_clk | output | 2 | Reference clocks |
| pad_oe | output | 1 | Pad output enable; 0 floats every output |

## Verification
The assertions assume three things about the inputs. Reset is held for several cycles of the slowest source. Configuration bits are quasi-static compared with the two-stage synchronizers. A mode change happens between periods of activity rather than inside a measured interval. The stimulus meets these assumptions. It writes the register on the falling edge of `clk_ref` and waits a settling interval before counting edges. It suspends the pulse-width monitor only around writes that change the mode, because an old-domain pulse may then border a new-domain pulse. Writes that change only enables or USB/IO selects land at arbitrary phases of the CPU and USB sources while the monitor is running.

// File: rtl/clkdiv_outmux_pkg.sv
`timescale 1ns/1ps
package clkdiv_outmux_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_TEST = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_HIZ  = 2'b11
  } out_mode_e;

  function automatic logic mode_is_test(input logic [1:0] m);
    return out_mode_e'(m) == MODE_TEST;
  endfunction

  function automatic logic mode_is_hiz(input logic [1:0] m);
    return out_mode_e'(m) == MODE_HIZ;
  endfunction

endpackage

// File: rtl/cdm_cfg_reg.sv
`timescale 1ns/1ps
module cdm_cfg_reg #(
  parameter int N_CPU = 4,
  parameter int N_SDR = 8,
  parameter int N_PCI = 6,
  parameter int N_USB = 2,
  parameter int N_REF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [1:0]         mode_i,
  input  logic [N_USB-1:0]   usb48_i,
  input  logic [N_CPU-1:0]   cpu_en_i,
  input  logic [N_SDR-1:0]   sdr_en_i,
  input  logic [N_PCI:0]     pci_en_i,
  input  logic [N_USB-1:0]   usb_en_i,
  input  logic               apic_en_i,
  input  logic [N_REF-1:0]   ref_en_i,
  output logic [1:0]         mode_q,
  output logic [N_USB-1:0]   usb48_q,
  output logic [N_CPU-1:0]   cpu_en_q,
  output logic [N_SDR-1:0]   sdr_en_q,
  output logic [N_PCI:0]     pci_en_q,
  output logic [N_USB-1:0]   usb_en_q,
  output logic               apic_en_q,
  output logic [N_REF-1:0]   ref_en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 2'b00;
      usb48_q   <= '1;
      cpu_en_q  <= '1;
      sdr_en_q  <= '1;
      pci_en_q  <= '1;
      usb_en_q  <= '1;
      apic_en_q <= 1'b1;
      ref_en_q  <= '1;
    end else if (we_i) begin
      mode_q    <= mode_i;
      usb48_q   <= usb48_i;
      cpu_en_q  <= cpu_en_i;
      sdr_en_q  <= sdr_en_i;
      pci_en_q  <= pci_en_i;
      usb_en_q  <= usb_en_i;
      apic_en_q <= apic_en_i;
      ref_en_q  <= ref_en_i;
    end
  end

  AST_CFG_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (mode_q == 2'b00) && (&usb48_q) && (&cpu_en_q) && (&sdr_en_q)
                      && (&pci_en_q) && (&usb_en_q) && apic_en_q && (&ref_en_q)); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable({mode_q, usb48_q, cpu_en_q, sdr_en_q, pci_en_q, usb_en_q,
                       apic_en_q, ref_en_q})); // R9

endmodule

// File: rtl/cdm_sync.sv
`timescale 1ns/1ps
module cdm_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/cdm_lane.sv
`timescale 1ns/1ps
module cdm_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic div4_i,
  input  logic en_i,
  output logic clk_o
);

  logic [1:0] cnt_q;
  logic [1:0] cnt_nx;
  logic [1:0] last_c;
  logic [1:0] half_c;
  logic       div4_q;
  logic       en_q;
  logic [2:0] hi_run_q;

  assign last_c = div4_q ? 2'd3 : 2'd1;
  assign half_c = div4_q ? 2'd2 : 2'd1;
  assign cnt_nx = cnt_q + 2'd1;

  // settings are taken only in the last (low) cycle of a period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div4_q <= 1'b0;
      en_q   <= 1'b0;
      clk_o  <= 1'b0;
    end else if (cnt_q == last_c) begin
      cnt_q  <= '0;
      div4_q <= div4_i;
      en_q   <= en_i;
      clk_o  <= en_i;
    end else begin
      cnt_q  <= cnt_nx;
      clk_o  <= en_q && (cnt_nx < half_c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_run_q <= '0;
    else if (clk_o) hi_run_q <= hi_run_q + 3'd1;
    else            hi_run_q <= '0;
  end

  AST_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_o) |-> hi_run_q == {1'b0, half_c}); // R8

  AST_EN_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> cnt_q == 2'd0); // R8

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> cnt_q == 2'd0); // R1

endmodule

// File: rtl/cdm_ref_gate.sv
`timescale 1ns/1ps
module cdm_ref_gate (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  output logic clk_o
);

  logic en_lo_q;

  // enable retimed on the falling edge, so it only moves while clk_i is low
  always_ff @(negedge clk_i) begin
    if (!rst_n) en_lo_q <= 1'b1;
    else        en_lo_q <= en_i;
  end

  assign clk_o = clk_i & en_lo_q;

endmodule

// File: rtl/clkdiv_outmux.sv
`timescale 1ns/1ps
module clkdiv_outmux
  import clkdiv_outmux_pkg::*;
#(
  parameter int N_CPU       = 4,
  parameter int N_SDR       = 8,
  parameter int N_PCI       = 6,
  parameter int N_USB       = 2,
  parameter int N_REF       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_cpu2x,
  input  logic             clk_usb2x,
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [N_USB-1:0] cfg_usb48,
  input  logic [N_CPU-1:0] cfg_cpu_en,
  input  logic [N_SDR-1:0] cfg_sdr_en,
  input  logic [N_PCI:0]   cfg_pci_en,
  input  logic [N_USB-1:0] cfg_usb_en,
  input  logic             cfg_apic_en,
  input  logic [N_REF-1:0] cfg_ref_en,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_SDR-1:0] sdr_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic             pci_f_clk,
  output logic [N_USB-1:0] usb_clk,
  output logic             apic_clk,
  output logic [N_REF-1:0] ref_clk,
  output logic             pad_oe
);

  localparam int NP1 = N_PCI + 1;
  localparam int WC  = 1 + N_CPU + N_SDR + NP1;
  localparam int WU  = 1 + 2 * N_USB;
  localparam logic [WC-1:0] RST_C = {1'b0, {(WC-1){1'b1}}};
  localparam logic [WU-1:0] RST_U = {1'b0, {(WU-1){1'b1}}};

  logic [1:0]       mode_q;
  logic [N_USB-1:0] usb48_q, usb_en_q;
  logic [N_CPU-1:0] cpu_en_q;
  logic [N_SDR-1:0] sdr_en_q;
  logic [NP1-1:0]   pci_en_q;
  logic             apic_en_q;
  logic [N_REF-1:0] ref_en_q;
  logic             test_q;

  cdm_cfg_reg #(
    .N_CPU(N_CPU), .N_SDR(N_SDR), .N_PCI(N_PCI), .N_USB(N_USB), .N_REF(N_REF)
  ) u_cfg (
    .clk(clk_ref), .rst_n(rst_n), .we_i(cfg_we), .mode_i(cfg_mode),
    .usb48_i(cfg_usb48), .cpu_en_i(cfg_cpu_en), .sdr_en_i(cfg_sdr_en),
    .pci_en_i(cfg_pci_en), .usb_en_i(cfg_usb_en), .apic_en_i(cfg_apic_en),
    .ref_en_i(cfg_ref_en), .mode_q(mode_q), .usb48_q(usb48_q),
    .cpu_en_q(cpu_en_q), .sdr_en_q(sdr_en_q), .pci_en_q(pci_en_q),
    .usb_en_q(usb_en_q), .apic_en_q(apic_en_q), .ref_en_q(ref_en_q)
  );

  assign test_q = mode_is_test(mode_q);
  assign pad_oe = !mode_is_hiz(mode_q);

  // ---------------- CPU domain (normal mode lanes) ----------------
  logic [WC-1:0]    csync;
  logic             test_c;
  logic [N_CPU-1:0] cpu_en_c;
  logic [N_SDR-1:0] sdr_en_c;
  logic [NP1-1:0]   pci_en_c;

  cdm_sync #(.W(WC), .STAGES(SYNC_STAGES), .RST_VAL(RST_C)) u_sync_cpu (
    .clk(clk_cpu2x), .rst_n(rst_n),
    .d_i({test_q, cpu_en_q, sdr_en_q, pci_en_q}), .q_o(csync)
  );
  assign {test_c, cpu_en_c, sdr_en_c, pci_en_c} = csync;

  logic [N_CPU-1:0] n_cpu, t_cpu;
  logic [N_SDR-1:0] n_sdr, t_sdr;
  logic [NP1-1:0]   n_pci, t_pci;
  logic [N_USB-1:0] n_usb, t_usb;

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    cdm_lane u_n (.clk(clk_cpu2x), .rst_n(rst_n), .div4_i(1'b0),
                  .en_i(cpu_en_c[i] & ~test_c), .clk_o(n_cpu[i]));
    cdm_lane u_t (.clk(clk_ref), .rst_n(rst_n), .div4_i(1'b0),
                  .en_i(cpu_en_q[i] & test_q), .clk_o(t_cpu[i]));
  end

  for (genvar i = 0; i < N_SDR; i++) begin : g_sdr
    cdm_lane u_n (.clk(clk_cpu2x), .rst_n(rst_n), .div4_i(1'b0),
                  .en_i(sdr_en_c[i] & ~test_c), .clk_o(n_sdr[i]));
    cdm_lane u_t (.clk(clk_ref), .rst_n(rst_n), .div4_i(1'b0),
                  .en_i(sdr_en_q[i] & test_q), .clk_o(t_sdr[i]));
  end

  for (genvar i = 0; i < NP1; i++) begin : g_pci
    cdm_lane u_n (.clk(clk_cpu2x), .rst_n(rst_n), .div4_i(1'b1),
                  .en_i(pci_en_c[i] & ~test_c), .clk_o(n_pci[i]));
    cdm_lane u_t (.clk(clk_ref), .rst_n(rst_n), .div4_i(1'b1),
                  .en_i(pci_en_q[i] & test_q), .clk_o(t_pci[i]));
  end

  // ---------------- USB domain ----------------
  logic [WU-1:0]    usync;
  logic             test_u;
  logic [N_USB-1:0] usb_en_u, usb48_u;

  cdm_sync #(.W(WU), .STAGES(SYNC_STAGES), .RST_VAL(RST_U)) u_sync_usb (
    .clk(clk_usb2x), .rst_n(rst_n),
    .d_i({test_q, usb_en_q, usb48_q}), .q_o(usync)
  );
  assign {test_u, usb_en_u, usb48_u} = usync;

  for (genvar i = 0; i < N_USB; i++) begin : g_usb
    cdm_lane u_n (.clk(clk_usb2x), .rst_n(rst_n), .div4_i(~usb48_u[i]),
                  .en_i(usb_en_u[i] & ~test_u), .clk_o(n_usb[i]));
    cdm_lane u_t (.clk(clk_ref), .rst_n(rst_n), .div4_i(~usb48_q[i]),
                  .en_i(usb_en_q[i] & test_q), .clk_o(t_usb[i]));
  end

  // the lane of the unselected mode is held low, so OR merges without a select glitch
  assign cpu_clk   = n_cpu | t_cpu;
  assign sdr_clk   = n_sdr | t_sdr;
  assign pci_clk   = n_pci[N_PCI-1:0] | t_pci[N_PCI-1:0];
  assign pci_f_clk = n_pci[N_PCI] | t_pci[N_PCI];
  assign usb_clk   = n_usb | t_usb;

  // ---------------- reference-rate outputs ----------------
  for (genvar i = 0; i < N_REF; i++) begin : g_ref
    cdm_ref_gate u_g (.clk_i(clk_ref), .rst_n(rst_n), .en_i(ref_en_q[i]),
                      .clk_o(ref_clk[i]));
  end
  cdm_ref_gate u_apic (.clk_i(clk_ref), .rst_n(rst_n), .en_i(apic_en_q),
                       .clk_o(apic_clk));

  AST_HIZ_OE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cfg_we && cfg_mode == 2'b11) |=> !pad_oe); // R4

  AST_DRIVE_OE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cfg_we && cfg_mode != 2'b11) |=> pad_oe); // R4

  AST_TEST_QUIET_CPU: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !test_q |=> $stable(t_cpu) && (t_cpu == '0 || $past(t_cpu) != '0)); // R5

endmodule

// File: tb/clkdiv_outmux_tb_top.sv
`timescale 1ns/1ps
module clkdiv_outmux_tb_top;

  localparam int NB  = 24;
  localparam int WIN = 2800;

  logic clk_cpu2x = 1'b0;
  logic clk_usb2x = 1'b0;
  logic clk_ref   = 1'b0;
  logic rst_n     = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [1:0] cfg_usb48 = 2'b11;
  logic [3:0] cfg_cpu_en = '1;
  logic [7:0] cfg_sdr_en = '1;
  logic [6:0] cfg_pci_en = '1;
  logic [1:0] cfg_usb_en = '1;
  logic       cfg_apic_en = 1'b1;
  logic [1:0] cfg_ref_en = '1;
  logic [3:0] cpu_clk;
  logic [7:0] sdr_clk;
  logic [5:0] pci_clk;
  logic       pci_f_clk;
  logic [1:0] usb_clk;
  logic       apic_clk;
  logic [1:0] ref_clk;
  logic       pad_oe;

  always #2 clk_cpu2x = ~clk_cpu2x;   // 250 MHz
  always #5 clk_usb2x = ~clk_usb2x;
  always #7 clk_ref   = ~clk_ref;

  clkdiv_outmux dut_i (
    .clk_cpu2x(clk_cpu2x), .clk_usb2x(clk_usb2x), .clk_ref(clk_ref), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_usb48(cfg_usb48),
    .cfg_cpu_en(cfg_cpu_en), .cfg_sdr_en(cfg_sdr_en), .cfg_pci_en(cfg_pci_en),
    .cfg_usb_en(cfg_usb_en), .cfg_apic_en(cfg_apic_en), .cfg_ref_en(cfg_ref_en),
    .cpu_clk(cpu_clk), .sdr_clk(sdr_clk), .pci_clk(pci_clk), .pci_f_clk(pci_f_clk),
    .usb_clk(usb_clk), .apic_clk(apic_clk), .ref_clk(ref_clk), .pad_oe(pad_oe)
  );

  // bit map: [3:0] cpu, [11:4] sdram, [17:12] pci, [18] pci free, [20:19] usb, [21] apic, [23:22] ref
  wire [NB-1:0] allo = {ref_clk, apic_clk, usb_clk, pci_f_clk, pci_clk, sdr_clk, cpu_clk};

  int        checks = 0;
  int        errors = 0;
  int        edges [NB];
  longint    rise_t [NB];
  int        bad [NB];
  logic      watch = 1'b0;
  logic [NB-1:0] prev = '0;

  function automatic bit width_ok(int i, longint w);
    if (i < 12)       return (w == 4) || (w == 14);
    else if (i < 19)  return (w == 8) || (w == 28);
    else if (i < 21)  return (w == 10) || (w == 20) || (w == 14) || (w == 28);
    else              return (w == 7);
  endfunction

  initial begin
    for (int i = 0; i < NB; i++) begin edges[i] = 0; rise_t[i] = -1; bad[i] = 0; end
  end

  always @(allo) begin
    for (int i = 0; i < NB; i++) begin
      if (allo[i] && !prev[i]) begin
        edges[i] = edges[i] + 1;
        rise_t[i] = $time;
      end else if (!allo[i] && prev[i]) begin
        if (watch && rise_t[i] >= 0 && !width_ok(i, $time - rise_t[i])) bad[i] = bad[i] + 1;
      end
    end
    prev = allo;
  end

  function automatic int exp_edges(int i, logic [1:0] m, logic [1:0] u, logic [NB-1:0] mask);
    bit t;
    int per;
    t = (m == 2'b01);
    if (!mask[i]) return 0;
    if (i < 12)      per = t ? 28 : 8;
    else if (i < 19) per = t ? 56 : 16;
    else if (i < 21) per = t ? (u[i-19] ? 28 : 56) : (u[i-19] ? 20 : 40);
    else             per = 14;
    return WIN / per;
  endfunction

  function automatic string tag_of(int i, logic [1:0] m, logic [NB-1:0] mask);
    if (!mask[i])     return "R7";
    if (i >= 21)      return "R6";
    if (m == 2'b01)   return "R5";
    if (i < 12)       return "R1";
    if (i < 19)       return "R2";
    return "R3";
  endfunction

  task automatic write_cfg(logic [1:0] m, logic [1:0] u, logic [NB-1:0] mask);
    @(negedge clk_ref);
    cfg_mode    = m;
    cfg_usb48   = u;
    cfg_cpu_en  = mask[3:0];
    cfg_sdr_en  = mask[11:4];
    cfg_pci_en  = mask[18:12];
    cfg_usb_en  = mask[20:19];
    cfg_apic_en = mask[21];
    cfg_ref_en  = mask[23:22];
    cfg_we      = 1'b1;
    @(negedge clk_ref);
    cfg_we      = 1'b0;
  endtask

  task automatic measure(logic [1:0] m, logic [1:0] u, logic [NB-1:0] mask, string pre);
    int e0 [NB];
    int got, ex;
    bit ok;
    for (int i = 0; i < NB; i++) e0[i] = edges[i];
    #(WIN);
    for (int i = 0; i < NB; i++) begin
      got = edges[i] - e0[i];
      ex  = exp_edges(i, m, u, mask);
      ok  = (ex == 0) ? (got == 0 && allo[i] == 1'b0) : (got >= ex - 1 && got <= ex + 1);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s%s bit %0d mode %b usb %b: edges actual %0d expected %0d",
                 pre, tag_of(i, m, mask), i, m, u, got, ex);
      end
    end
    checks++;
    if (pad_oe !== (m != 2'b11)) begin
      errors++;
      $display("FAIL %sR4 pad_oe mode %b: actual %b expected %b", pre, m, pad_oe, (m != 2'b11));
    end
  endtask

  initial begin
    #(800_000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NB-1:0] pats [4];
    logic [1:0] cur_mode;
    pats[0] = '1;
    pats[1] = 24'hA5C3_96;
    pats[2] = 24'h5A3C_69;
    pats[3] = '0;
    #200;
    @(negedge clk_ref);
    rst_n = 1'b1;
    #200;
    watch = 1'b1;
    // reset defaults: normal mode, all outputs on, 48 MHz selects
    measure(2'b00, 2'b11, '1, "R9/");
    cur_mode = 2'b00;
    for (int m = 0; m < 4; m++) begin
      for (int u = 0; u < 4; u++) begin
        for (int p = 0; p < 4; p++) begin
          if (m[1:0] != cur_mode) watch = 1'b0;
          write_cfg(m[1:0], u[1:0], pats[p]);
          cur_mode = m[1:0];
          #200;
          watch = 1'b1;
          measure(m[1:0], u[1:0], pats[p], "");
        end
      end
    end
    // reset brings back the defaults after a non-default setting
    watch = 1'b0;
    write_cfg(2'b01, 2'b00, '0);
    #200;
    @(negedge clk_ref);
    rst_n = 1'b0;
    #200;
    @(negedge clk_ref);
    rst_n = 1'b1;
    #200;
    watch = 1'b1;
    measure(2'b00, 2'b11, '1, "R9/");
    // no shortened or merged pulse while settings change inside a mode
    for (int i = 0; i < NB; i++) begin
      checks++;
      if (bad[i] != 0) begin
        errors++;
        $display("FAIL R8 bit %0d illegal high pulses: actual %0d expected 0", i, bad[i]);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule